// File: doc/BRIEF.md
# DTMF Digit Timing Qualifier

This block sits behind a DTMF tone decoder and decides, purely by timing, when a decoded digit counts as received and when it has ended. Each clock it samples a level pair from the decoder: a flag saying a valid tone pair is present, and the 4-bit code of that pair. Short bursts are thrown away. A tone that persists long enough is accepted. Brief gaps are bridged, and the result is released only after a hold time once the tone has stopped.

The host sees two things. `rx_code` is the latched code of the accepted digit. `steer_n` is an active-low steering bit that falls a fraction of a millisecond after the code has settled, so the host can capture `rx_code` on that falling edge. The input `fast_mode` picks between a fast timing set and a normal timing set. The fast set trades noise immunity for throughput.

All three raw inputs pass through a two-flop synchronizer. They are held levels rather than a data stream, so there is no valid/ready handshake and no back-pressure: the block only observes. Timing comes from an internal 0.1 ms sub-tick and a 1 ms tick, both divided from the system clock. The divider is restarted on every state change, so each window is measured from the moment its state is entered.

Top module: `dtmf_timing_qualifier`

## Requirements
- R1: While `rst_n` is low, and immediately after it falls (asynchronously), `steer_n` is 1 and `rx_code` is 0, and all timers restart from zero.
- R2: A continuous tone shorter than 10 ms in fast mode (`fast_mode`=1), or shorter than 24 ms in normal mode (`fast_mode`=0), never makes `steer_n` fall. `steer_n` stays 1 for as long as qualification is in progress.
- R3: A continuous tone of 35 ms or more in fast mode, or 49 ms or more in normal mode, is accepted. With default parameters, acceptance happens 26 ms (fast) or 41 ms (normal) after the synchronized tone starts, and `rx_code` then equals the 4-bit input code unchanged.
- R4: `rx_code` takes the new code 0.6 ms before `steer_n` falls, and it does not change on the cycle `steer_n` falls.
- R5: Before acceptance, a gap in the valid flag of 0.4 ms or less does not restart qualification. A gap of 0.5 ms or more restarts it, and timing counts again from the tone's return.
- R6: After acceptance, a gap of up to 3 ms (fast) or 10 ms (normal) followed by the tone's return does not release the digit. After a longer gap, the release happens one hold time after the gap began, even if the tone has already come back.
- R7: Once the tone stops, `steer_n` returns to 1 and `rx_code` returns to 0 after a hold time of 20 ms (fast) or 28 ms (normal).
- R8: While `steer_n` is 0, a change of the input code, whether with no pause or with a pause shorter than the hold time, leaves `rx_code` at the accepted value and keeps `steer_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-down reset |
| fast_mode | input | 1 | 1 selects fast timing, 0 selects normal timing |
| tone_valid | input | 1 | Raw decoder flag: a valid tone pair is present |
| tone_code | input | 4 | Raw decoder code of the present tone pair |
| rx_code | output | 4 | Latched code of the accepted digit, 0 when none is held |
| steer_n | output | 1 | Active-low steering bit: 0 while an accepted digit is held |

## Verification
The hardest behaviour to reach from the ports is the post-acceptance gap that is too long to bridge, yet shorter than the hold time. There the tone is back on the inputs, but the block must still release at the hold deadline and then qualify the same tone from scratch. The stimulus gets there by accepting a digit, removing the tone for 5 ms in fast mode and restoring it for a long stretch. It then checks that `steer_n` rises 20 ms after the gap began and falls again one acceptance window later. The sub-millisecond pre-acceptance gaps are driven in exact multiples of the divided tick, on either side of the 0.4 ms limit.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_QUALIFY = 2'd1,
    ST_PRESENT = 2'd2,
    ST_HOLD    = 2'd3
  } dtq_state_e;

  function automatic int unsigned dtq_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dtq_sync.sv
module dtq_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d[i];
        stab_q <= meta_q;
      end
    end
    assign q[i] = stab_q;
  end

endmodule

// File: rtl/dtq_tick_gen.sv
module dtq_tick_gen #(
  parameter int unsigned CLKS_PER_SUB = 20000,
  parameter int unsigned SUB_PER_MS   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic sub_tick,
  output logic ms_tick
);

  localparam int unsigned CW = $clog2(CLKS_PER_SUB + 1);
  localparam int unsigned SW = $clog2(SUB_PER_MS + 1);

  logic [CW-1:0] clk_cnt_q;
  logic [SW-1:0] sub_cnt_q;

  assign sub_tick = (clk_cnt_q == CW'(CLKS_PER_SUB - 1));
  assign ms_tick  = sub_tick && (sub_cnt_q == SW'(SUB_PER_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_cnt_q <= '0;
      sub_cnt_q <= '0;
    end else if (restart) begin
      clk_cnt_q <= '0;
      sub_cnt_q <= '0;
    end else if (sub_tick) begin
      clk_cnt_q <= '0;
      sub_cnt_q <= ms_tick ? '0 : sub_cnt_q + SW'(1);
    end else begin
      clk_cnt_q <= clk_cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/dtq_limits.sv
module dtq_limits #(
  parameter int unsigned MS_W         = 6,
  parameter int unsigned ACC_FAST_MS  = 26,
  parameter int unsigned ACC_NORM_MS  = 41,
  parameter int unsigned GAP_FAST_MS  = 3,
  parameter int unsigned GAP_NORM_MS  = 10,
  parameter int unsigned HOLD_FAST_MS = 20,
  parameter int unsigned HOLD_NORM_MS = 28
) (
  input  logic            fast,
  output logic [MS_W-1:0] acc_last,
  output logic [MS_W-1:0] gap_max,
  output logic [MS_W-1:0] hold_last
);

  always_comb begin
    if (fast) begin
      acc_last  = MS_W'(ACC_FAST_MS - 1);
      gap_max   = MS_W'(GAP_FAST_MS);
      hold_last = MS_W'(HOLD_FAST_MS - 1);
    end else begin
      acc_last  = MS_W'(ACC_NORM_MS - 1);
      gap_max   = MS_W'(GAP_NORM_MS);
      hold_last = MS_W'(HOLD_NORM_MS - 1);
    end
  end

endmodule

// File: rtl/dtmf_timing_qualifier.sv
module dtmf_timing_qualifier
  import dtq_pkg::*;
#(
  parameter int unsigned CODE_W       = 4,
  parameter int unsigned CLKS_PER_SUB = 20000,
  parameter int unsigned SUB_PER_MS   = 10,
  parameter int unsigned ACC_FAST_MS  = 26,
  parameter int unsigned ACC_NORM_MS  = 41,
  parameter int unsigned GAP_FAST_MS  = 3,
  parameter int unsigned GAP_NORM_MS  = 10,
  parameter int unsigned HOLD_FAST_MS = 20,
  parameter int unsigned HOLD_NORM_MS = 28,
  parameter int unsigned PRE_GAP_SUB  = 4,
  parameter int unsigned STROBE_SUB   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              tone_valid,
  input  logic [CODE_W-1:0] tone_code,
  output logic [CODE_W-1:0] rx_code,
  output logic              steer_n
);

  localparam int unsigned MAX_MS = dtq_max(dtq_max(ACC_FAST_MS, ACC_NORM_MS),
                                   dtq_max(dtq_max(HOLD_FAST_MS, HOLD_NORM_MS),
                                           dtq_max(GAP_FAST_MS, GAP_NORM_MS)));
  localparam int unsigned MS_W   = $clog2(MAX_MS + 2);
  localparam int unsigned SUB_W  = $clog2(dtq_max(PRE_GAP_SUB, STROBE_SUB) + 2);
  localparam int unsigned SYNC_W = CODE_W + 2;

  logic [SYNC_W-1:0] sync_q;
  logic              fast_s, valid_s;
  logic [CODE_W-1:0] code_s;

  dtq_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({fast_mode, tone_valid, tone_code}),
    .q     (sync_q)
  );
  assign {fast_s, valid_s, code_s} = sync_q;

  logic [MS_W-1:0] acc_last, gap_max, hold_last;

  dtq_limits #(
    .MS_W(MS_W), .ACC_FAST_MS(ACC_FAST_MS), .ACC_NORM_MS(ACC_NORM_MS),
    .GAP_FAST_MS(GAP_FAST_MS), .GAP_NORM_MS(GAP_NORM_MS),
    .HOLD_FAST_MS(HOLD_FAST_MS), .HOLD_NORM_MS(HOLD_NORM_MS)
  ) u_limits (
    .fast      (fast_s),
    .acc_last  (acc_last),
    .gap_max   (gap_max),
    .hold_last (hold_last)
  );

  dtq_state_e        state_q, state_d;
  logic [MS_W-1:0]   ms_q, ms_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [CODE_W-1:0] cand_q, cand_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              steer_q, steer_d;
  logic              requal;
  logic              sub_tick, ms_tick;
  logic              tick_restart;

  assign tick_restart = (state_d != state_q) || requal;

  dtq_tick_gen #(.CLKS_PER_SUB(CLKS_PER_SUB), .SUB_PER_MS(SUB_PER_MS)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (tick_restart),
    .sub_tick (sub_tick),
    .ms_tick  (ms_tick)
  );

  always_comb begin
    state_d = state_q;
    ms_d    = ms_q;
    sub_d   = sub_q;
    cand_d  = cand_q;
    code_d  = code_q;
    steer_d = steer_q;
    requal  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (valid_s) begin
          state_d = ST_QUALIFY;
          cand_d  = code_s;
          ms_d    = '0;
          sub_d   = '0;
        end
      end
      ST_QUALIFY: begin
        if (valid_s && (code_s != cand_q)) begin
          requal = 1'b1;
          cand_d = code_s;
          ms_d   = '0;
          sub_d  = '0;
        end else if (ms_tick && (ms_q == acc_last)) begin
          state_d = ST_PRESENT;
          code_d  = cand_q;
          sub_d   = '0;
        end else begin
          if (ms_tick) ms_d = ms_q + MS_W'(1);
          if (valid_s) begin
            sub_d = '0;
          end else if (sub_tick) begin
            if (sub_q == SUB_W'(PRE_GAP_SUB)) state_d = ST_IDLE;
            else                              sub_d   = sub_q + SUB_W'(1);
          end
        end
      end
      ST_PRESENT: begin
        if (steer_q) begin
          if (sub_tick) begin
            if (sub_q == SUB_W'(STROBE_SUB - 1)) steer_d = 1'b0;
            else                                 sub_d   = sub_q + SUB_W'(1);
          end
        end else if (!valid_s) begin
          state_d = ST_HOLD;
          ms_d    = '0;
        end
      end
      ST_HOLD: begin
        if (valid_s && (ms_q <= gap_max)) begin
          state_d = ST_PRESENT;
        end else if (ms_tick) begin
          if (ms_q == hold_last) begin
            state_d = ST_IDLE;
            code_d  = '0;
            steer_d = 1'b1;
            ms_d    = '0;
          end else begin
            ms_d = ms_q + MS_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ms_q    <= '0;
      sub_q   <= '0;
      cand_q  <= '0;
      code_q  <= '0;
      steer_q <= 1'b1;
    end else begin
      state_q <= state_d;
      ms_q    <= ms_d;
      sub_q   <= sub_d;
      cand_q  <= cand_d;
      code_q  <= code_d;
      steer_q <= steer_d;
    end
  end

  assign rx_code = code_q;
  assign steer_n = steer_q;

endmodule

// File: rtl/dtq_checker.sv
module dtq_checker
  import dtq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       steer_n,
  input logic [3:0] rx_code,
  input logic [1:0] state_q
);

  assert_idle_steer_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> steer_n);

  assert_qualify_steer_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUALIFY) |-> steer_n);

  assert_code_before_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_n) |-> $stable(rx_code));

  assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_n) |-> (rx_code == 4'd0));

  assert_code_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!steer_n && $past(!steer_n)) |-> $stable(rx_code));

endmodule

bind dtmf_timing_qualifier dtq_checker u_dtq_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .steer_n (steer_n),
  .rx_code (rx_code),
  .state_q (state_q)
);

// File: tb/dtmf_timing_qualifier_tb_top.sv
module dtmf_timing_qualifier_tb_top;

  localparam int unsigned SUB_CLKS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_mode = 1'b1;
  logic       tone_valid = 1'b0;
  logic [3:0] tone_code = 4'd0;
  logic [3:0] rx_code;
  logic       steer_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dtmf_timing_qualifier #(.CLKS_PER_SUB(SUB_CLKS)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_mode  (fast_mode),
    .tone_valid (tone_valid),
    .tone_code  (tone_code),
    .rx_code    (rx_code),
    .steer_n    (steer_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // wait n units of 0.1 ms, landing on a falling edge
  task automatic wait_sub(input int n);
    repeat (n * SUB_CLKS) @(negedge clk);
  endtask

  task automatic tone(input logic on, input logic [3:0] c);
    tone_valid = on;
    tone_code  = c;
  endtask

  task automatic settle();
    tone(1'b0, 4'd0);
    wait_sub(350);
  endtask

  task automatic test_reset_state();
    chk("R1 steer during reset", steer_n, 1);
    chk("R1 code during reset", rx_code, 0);
  endtask

  task automatic test_short_reject(input logic fast, input int len_sub, input string req);
    int lows = 0;
    fast_mode = fast;
    wait_sub(2);
    tone(1'b1, 4'd7);
    for (int i = 0; i < 500; i++) begin
      if (i == len_sub) tone(1'b0, 4'd7);
      @(negedge clk);
      if (!steer_n) lows++;
    end
    wait_sub(450);
    chk(req, lows, 0);
    settle();
  endtask

  task automatic test_accept(input logic fast, input int acc_sub, input int hold_sub,
                             input logic [3:0] c);
    fast_mode = fast;
    wait_sub(2);
    tone(1'b1, c);
    wait_sub(acc_sub - 5);
    chk("R3 not yet accepted", steer_n, 1);
    wait_sub(8);
    chk("R4 code ahead of strobe", rx_code, c);
    chk("R4 steer still high", steer_n, 1);
    wait_sub(7);
    chk("R3 accepted steer", steer_n, 0);
    chk("R3 accepted code", rx_code, c);
    wait_sub(500 - acc_sub - 10);
    tone(1'b0, c);
    wait_sub(hold_sub - 10);
    chk("R7 held before hold end", steer_n, 0);
    wait_sub(20);
    chk("R7 released steer", steer_n, 1);
    chk("R7 released code", rx_code, 0);
    settle();
  endtask

  task automatic test_pre_gap();
    fast_mode = 1'b1;
    wait_sub(2);
    tone(1'b1, 4'd2);
    wait_sub(150);
    tone(1'b0, 4'd2);
    wait_sub(2);
    tone(1'b1, 4'd2);
    wait_sub(118);
    chk("R5 short gap bridged", steer_n, 0);
    settle();
    tone(1'b1, 4'd6);
    wait_sub(150);
    tone(1'b0, 4'd6);
    wait_sub(10);
    tone(1'b1, 4'd6);
    wait_sub(140);
    chk("R5 long gap restarts", steer_n, 1);
    wait_sub(130);
    chk("R5 accepted after restart", steer_n, 0);
    settle();
  endtask

  task automatic test_post_gap();
    fast_mode = 1'b1;
    wait_sub(2);
    tone(1'b1, 4'd3);
    wait_sub(300);
    tone(1'b0, 4'd3);
    wait_sub(20);
    tone(1'b1, 4'd3);
    wait_sub(180);
    tone(1'b0, 4'd3);
    wait_sub(100);
    chk("R6 2ms gap not released", steer_n, 0);
    wait_sub(120);
    chk("R6 release after real end", steer_n, 1);
    settle();
    tone(1'b1, 4'd3);
    wait_sub(300);
    tone(1'b0, 4'd3);
    wait_sub(50);
    tone(1'b1, 4'd3);
    wait_sub(170);
    chk("R6 5ms gap released at hold", steer_n, 1);
    wait_sub(250);
    chk("R6 requalified steer", steer_n, 0);
    chk("R6 requalified code", rx_code, 3);
    settle();
  endtask

  task automatic test_code_change();
    fast_mode = 1'b1;
    wait_sub(2);
    tone(1'b1, 4'd5);
    wait_sub(300);
    tone(1'b1, 4'd9);
    wait_sub(100);
    chk("R8 no-pause change steer", steer_n, 0);
    chk("R8 no-pause change code", rx_code, 5);
    wait_sub(50);
    tone(1'b0, 4'd9);
    wait_sub(100);
    tone(1'b1, 4'd1);
    wait_sub(50);
    chk("R8 short-pause change steer", steer_n, 0);
    chk("R8 short-pause change code", rx_code, 5);
    wait_sub(100);
    settle();
  endtask

  task automatic test_async_reset();
    fast_mode = 1'b1;
    wait_sub(2);
    tone(1'b1, 4'd12);
    wait_sub(300);
    chk("R1 digit held before reset", steer_n, 0);
    rst_n = 1'b0;
    #1;
    chk("R1 async steer", steer_n, 1);
    chk("R1 async code", rx_code, 0);
    tone(1'b0, 4'd0);
    wait_sub(2);
    rst_n = 1'b1;
    wait_sub(2);
    chk("R1 idle after reset", steer_n, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    wait_sub(2);
    test_short_reject(1'b1, 80, "R2 fast 8ms tone rejected");
    test_short_reject(1'b0, 200, "R2 normal 20ms tone rejected");
    test_accept(1'b1, 260, 200, 4'd5);
    test_accept(1'b0, 410, 280, 4'd0);
    test_pre_gap();
    test_post_gap();
    test_code_change();
    test_async_reset();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule